// File: doc/BRIEF.md
# Descriptor Auto-Poll Timer

This block tells the transmit and receive DMA engines of a network controller when to look at their descriptor rings again. A DMA engine that finds a descriptor still owned by software goes idle. It needs a later prompt to re-read the ownership bit. The block gives that prompt in two ways: a periodic request from a per-direction timer, and an immediate request when software pokes that direction's demand strobe.

Each direction has its own configuration: a 4-bit timeout and a cycle-length select. The poll period is the timeout multiplied by one cycle. A cycle is a fixed count of reference bit-time ticks. That count is larger for the long select and is multiplied again when the link runs at the slow speed. With default parameters a normal cycle is 512 ticks and a long cycle is 8192 ticks, and the slow-speed factor is 10. A timeout of zero turns the timer off for that direction. A request output stays high until the DMA engine acknowledges it. Any triggers that arrive before the acknowledge merge into one request.

Top module: `desc_poll_timer`

## Requirements
- R1: After reset both request outputs are low. The transmit timeout is 0, so transmit does not auto-poll. The receive timeout is 1 with the normal cycle, so receive auto-polls.
- R2: After a timer restart, a direction's request rises immediately after the clock edge that samples the N-th `bitTick`. N = timeout × cycle ticks. With the normal select at the fast speed, cycle ticks = NORM_TICKS. The timer then restarts by itself.
- R3: A timeout of 0 stops the timer, and that direction raises no request except on demand.
- R4: The long select (`cfgTxLong`/`cfgRxLong` = 1) uses LONG_TICKS per cycle in place of NORM_TICKS.
- R5: While `linkFast` is 0 the cycle tick count is multiplied by SLOW_MULT.
- R6: A demand strobe sampled at an edge raises that direction's request right after that edge. It also restarts that direction's timer from zero.
- R7: A configuration write (`cfgWe` = 1) restarts a direction's timer when it changes that direction's timeout or long select. A write that leaves both unchanged does not disturb the running period.
- R8: A raised request stays high until its acknowledge is sampled. It is low after that edge unless a new trigger arrives at the same edge.
- R9: Several triggers before an acknowledge produce one request, which a single acknowledge clears.
- R10: A trigger sampled at the same edge as an acknowledge leaves the request high.
- R11: The two directions have separate timers, requests and acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Reference bit-time tick, one cycle wide |
| linkFast | input | 1 | 1 = fast link speed, 0 = slow (cycle scaled by SLOW_MULT) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgTxTmo | input | 4 | New transmit poll timeout, in cycles (0 = off) |
| cfgTxLong | input | 1 | New transmit cycle select, 1 = long |
| cfgRxTmo | input | 4 | New receive poll timeout, in cycles (0 = off) |
| cfgRxLong | input | 1 | New receive cycle select, 1 = long |
| txDemand | input | 1 | Software transmit poll demand |
| rxDemand | input | 1 | Software receive poll demand |
| txPollAck | input | 1 | Transmit DMA accepts the request |
| rxPollAck | input | 1 | Receive DMA accepts the request |
| txPollReq | output | 1 | Transmit ring poll request, held until acknowledged |
| rxPollReq | output | 1 | Receive ring poll request, held until acknowledged |

## Verification
The bench probes the exact edge of expiry, one cycle early and on time, under the normal select, the long select and the slow speed. An off-by-one in the tick count or a missing speed factor shows as a request one or many cycles out of place. A demand in mid-period followed by the old expiry point catches a timer that is not restarted: it would fire at a stale time. Rewrites of the timeout with a new value and with the same value separate a design that never reloads from one that reloads on every write. Repeated demands, demand coinciding with acknowledge, and mixed per-direction timeouts expose lost or duplicated requests and crosstalk between the directions.

// File: rtl/desc_poll_pkg.sv
package desc_poll_pkg;

  localparam int TMO_W   = 4;
  localparam int NUM_DIR = 2;
  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;

  // stored per-direction configuration
  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic             longSel;
  } dirCfg_t;

  // strobes and settings from control to one timer datapath
  typedef struct packed {
    logic             restart;
    logic             run;
    logic             longSel;
    logic [TMO_W-1:0] tmo;
  } tmrCtl_t;

endpackage

// File: rtl/desc_poll_dp.sv
module desc_poll_dp
  import desc_poll_pkg::*;
#(
  parameter int NORM_TICKS = 512,
  parameter int LONG_TICKS = 8192,
  parameter int SLOW_MULT  = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitTick,
  input  logic    linkFast,
  input  tmrCtl_t ctl,
  output logic    expire
);

  localparam int MAX_TICKS = LONG_TICKS * SLOW_MULT;
  localparam int PRE_W     = $clog2(MAX_TICKS + 1);
  localparam logic [PRE_W-1:0] LAST_NF = PRE_W'(NORM_TICKS - 1);
  localparam logic [PRE_W-1:0] LAST_NS = PRE_W'(NORM_TICKS * SLOW_MULT - 1);
  localparam logic [PRE_W-1:0] LAST_LF = PRE_W'(LONG_TICKS - 1);
  localparam logic [PRE_W-1:0] LAST_LS = PRE_W'(LONG_TICKS * SLOW_MULT - 1);

  logic [PRE_W-1:0] preCnt;
  logic [TMO_W-1:0] cycCnt;
  logic [PRE_W-1:0] lastIdx;
  logic             tickLast;
  logic             periodDone;

  // cycle length chosen by select and link speed
  always_comb begin
    case ({ctl.longSel, linkFast})
      2'b00:   lastIdx = LAST_NS;
      2'b01:   lastIdx = LAST_NF;
      2'b10:   lastIdx = LAST_LS;
      default: lastIdx = LAST_LF;
    endcase
  end

  // >= keeps a speed change mid-cycle from overshooting
  assign tickLast   = bitTick && (preCnt >= lastIdx);
  assign periodDone = ({1'b0, cycCnt} + 1'b1) >= {1'b0, ctl.tmo};
  assign expire     = ctl.run && tickLast && periodDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cycCnt <= '0;
    end else if (ctl.restart || !ctl.run) begin
      preCnt <= '0;
      cycCnt <= '0;
    end else if (bitTick) begin
      if (tickLast) begin
        preCnt <= '0;
        cycCnt <= periodDone ? '0 : cycCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  AST_IDLE_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tmo == '0) |-> !expire);  // R3
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> (preCnt == '0 && cycCnt == '0));  // R6
  AST_CYC_BELOW_TMO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (cycCnt < ctl.tmo));  // R2

endmodule

// File: rtl/desc_poll_ctrl.sv
module desc_poll_ctrl
  import desc_poll_pkg::*;
#(
  parameter int TX_TMO_RST = 0,
  parameter int RX_TMO_RST = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWe,
  input  dirCfg_t [NUM_DIR-1:0]         cfgNew,
  input  logic    [NUM_DIR-1:0]         demand,
  input  logic    [NUM_DIR-1:0]         ack,
  input  logic    [NUM_DIR-1:0]         expire,
  output tmrCtl_t [NUM_DIR-1:0]         tmrCtl,
  output logic    [NUM_DIR-1:0]         pollReq
);

  dirCfg_t [NUM_DIR-1:0] cfgQ;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam int RST_TMO = (d == DIR_TX) ? TX_TMO_RST : RX_TMO_RST;

    logic cfgChg;
    logic trigger;

    assign cfgChg  = cfgWe && (cfgNew[d] != cfgQ[d]);
    assign trigger = demand[d] || expire[d];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[d] <= '{tmo: TMO_W'(RST_TMO), longSel: 1'b0};
      end else if (cfgWe) begin
        cfgQ[d] <= cfgNew[d];
      end
    end

    // new trigger wins over a coincident acknowledge
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pollReq[d] <= 1'b0;
      end else begin
        pollReq[d] <= (pollReq[d] && !ack[d]) || trigger;
      end
    end

    always_comb begin
      tmrCtl[d].restart = demand[d] || cfgChg;
      tmrCtl[d].run     = (cfgQ[d].tmo != '0);
      tmrCtl[d].longSel = cfgQ[d].longSel;
      tmrCtl[d].tmo     = cfgQ[d].tmo;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (pollReq[d] && !ack[d]) |=> pollReq[d]);  // R8
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rstN)
      (pollReq[d] && ack[d] && !demand[d] && !expire[d]) |=> !pollReq[d]);  // R8
    AST_DEMAND_REQ: assert property (@(posedge clk) disable iff (!rstN)
      demand[d] |=> pollReq[d]);  // R6
    AST_EXPIRE_REQ: assert property (@(posedge clk) disable iff (!rstN)
      expire[d] |=> pollReq[d]);  // R2
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgNew[d].tmo == '0) |=> !expire[d]);  // R3
  end

endmodule

// File: rtl/desc_poll_timer.sv
module desc_poll_timer
  import desc_poll_pkg::*;
#(
  parameter int NORM_TICKS = 512,
  parameter int LONG_TICKS = 8192,
  parameter int SLOW_MULT  = 10,
  parameter int TX_TMO_RST = 0,
  parameter int RX_TMO_RST = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             linkFast,
  input  logic             cfgWe,
  input  logic [TMO_W-1:0] cfgTxTmo,
  input  logic             cfgTxLong,
  input  logic [TMO_W-1:0] cfgRxTmo,
  input  logic             cfgRxLong,
  input  logic             txDemand,
  input  logic             rxDemand,
  input  logic             txPollAck,
  input  logic             rxPollAck,
  output logic             txPollReq,
  output logic             rxPollReq
);

  dirCfg_t [NUM_DIR-1:0] cfgNew;
  tmrCtl_t [NUM_DIR-1:0] tmrCtl;
  logic    [NUM_DIR-1:0] expire;
  logic    [NUM_DIR-1:0] pollReq;
  logic    [NUM_DIR-1:0] demand;
  logic    [NUM_DIR-1:0] ack;

  assign cfgNew[DIR_TX] = '{tmo: cfgTxTmo, longSel: cfgTxLong};
  assign cfgNew[DIR_RX] = '{tmo: cfgRxTmo, longSel: cfgRxLong};
  assign demand[DIR_TX] = txDemand;
  assign demand[DIR_RX] = rxDemand;
  assign ack[DIR_TX]    = txPollAck;
  assign ack[DIR_RX]    = rxPollAck;
  assign txPollReq      = pollReq[DIR_TX];
  assign rxPollReq      = pollReq[DIR_RX];

  desc_poll_ctrl #(
    .TX_TMO_RST(TX_TMO_RST),
    .RX_TMO_RST(RX_TMO_RST)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgNew (cfgNew),
    .demand (demand),
    .ack    (ack),
    .expire (expire),
    .tmrCtl (tmrCtl),
    .pollReq(pollReq)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_tmr
    desc_poll_dp #(
      .NORM_TICKS(NORM_TICKS),
      .LONG_TICKS(LONG_TICKS),
      .SLOW_MULT (SLOW_MULT)
    ) dp_i (
      .clk     (clk),
      .rstN    (rstN),
      .bitTick (bitTick),
      .linkFast(linkFast),
      .ctl     (tmrCtl[d]),
      .expire  (expire[d])
    );
  end

endmodule

// File: tb/desc_poll_timer_tb_top.sv
module desc_poll_timer_tb_top;

  localparam int NORM = 4;
  localparam int LONG = 12;
  localparam int SLOW = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b1;
  logic       linkFast = 1'b1;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgTxTmo = 4'd0;
  logic       cfgTxLong = 1'b0;
  logic [3:0] cfgRxTmo = 4'd0;
  logic       cfgRxLong = 1'b0;
  logic       txDemand = 1'b0;
  logic       rxDemand = 1'b0;
  logic       txPollAck = 1'b0;
  logic       rxPollAck = 1'b0;
  logic       txPollReq;
  logic       rxPollReq;

  int cyc = 0;
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  tx;
    logic  rx;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  desc_poll_timer #(
    .NORM_TICKS(NORM),
    .LONG_TICKS(LONG),
    .SLOW_MULT (SLOW)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .linkFast (linkFast),
    .cfgWe    (cfgWe),
    .cfgTxTmo (cfgTxTmo),
    .cfgTxLong(cfgTxLong),
    .cfgRxTmo (cfgRxTmo),
    .cfgRxLong(cfgRxLong),
    .txDemand (txDemand),
    .rxDemand (rxDemand),
    .txPollAck(txPollAck),
    .rxPollAck(rxPollAck),
    .txPollReq(txPollReq),
    .rxPollReq(rxPollReq)
  );

  // monitor: compares outputs against the queued expectations
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      expItem_t e;
      e = expQ.pop_front();
      vectors++;
      if (e.at < cyc) begin
        errors++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
      end else if (txPollReq !== e.tx || rxPollReq !== e.rx) begin
        errors++;
        $display("FAIL %s: cycle %0d tx/rx req actual %b%b expected %b%b",
                 e.tag, cyc, txPollReq, rxPollReq, e.tx, e.rx);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expectNow(logic tx, logic rx, string tag);
    expItem_t e;
    e.at = cyc;
    e.tx = tx;
    e.rx = rx;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic writeCfg(logic [3:0] tt, logic tl, logic [3:0] rt, logic rl);
    cfgWe = 1'b1;
    cfgTxTmo = tt;
    cfgTxLong = tl;
    cfgRxTmo = rt;
    cfgRxLong = rl;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic pulseDemand(logic tx, logic rx);
    txDemand = tx;
    rxDemand = rx;
    step();
    txDemand = 1'b0;
    rxDemand = 1'b0;
  endtask

  task automatic pulseAck(logic tx, logic rx);
    txPollAck = tx;
    rxPollAck = rx;
    step();
    txPollAck = 1'b0;
    rxPollAck = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finishRun();
  end

  initial begin
    step(4);
    rstN = 1'b1;
    // R1: reset state, then receive default period of one normal cycle
    expectNow(1'b0, 1'b0, "R1 reset outputs low");
    step(3);
    expectNow(1'b0, 1'b0, "R1 rx default not yet due");
    step();
    expectNow(1'b0, 1'b1, "R1 rx default period, tx off");
    writeCfg(4'd0, 1'b0, 4'd0, 1'b0);
    expectNow(1'b0, 1'b1, "R8 rx held without ack");
    step(10);
    expectNow(1'b0, 1'b1, "R8 rx still held");
    pulseAck(1'b0, 1'b1);
    expectNow(1'b0, 1'b0, "R8 ack clears rx");
    step(20);
    expectNow(1'b0, 1'b0, "R3 zero timeout stays quiet");

    // R2: tx timeout 2, normal, fast -> 8 ticks
    writeCfg(4'd2, 1'b0, 4'd0, 1'b0);
    expectNow(1'b0, 1'b0, "R2 after restart");
    step(7);
    expectNow(1'b0, 1'b0, "R2 one tick early");
    step();
    expectNow(1'b1, 1'b0, "R2 tx expiry");
    pulseAck(1'b1, 1'b0);
    expectNow(1'b0, 1'b0, "R8 tx ack clears");
    writeCfg(4'd0, 1'b0, 4'd0, 1'b0);
    step(20);
    expectNow(1'b0, 1'b0, "R3 tx off after write of zero");

    // R4: long cycle, timeout 1 -> 12 ticks
    writeCfg(4'd1, 1'b1, 4'd0, 1'b0);
    step(11);
    expectNow(1'b0, 1'b0, "R4 long one tick early");
    step();
    expectNow(1'b1, 1'b0, "R4 long expiry");
    pulseAck(1'b1, 1'b0);
    expectNow(1'b0, 1'b0, "R4 ack");
    writeCfg(4'd0, 1'b0, 4'd0, 1'b0);

    // R5: slow link, rx timeout 1 normal -> 12 ticks
    linkFast = 1'b0;
    writeCfg(4'd0, 1'b0, 4'd1, 1'b0);
    step(11);
    expectNow(1'b0, 1'b0, "R5 slow one tick early");
    step();
    expectNow(1'b0, 1'b1, "R5 slow expiry");
    pulseAck(1'b0, 1'b1);
    expectNow(1'b0, 1'b0, "R5 ack");
    writeCfg(4'd0, 1'b0, 4'd0, 1'b0);
    linkFast = 1'b1;

    // R6: demand mid-period restarts the timer
    writeCfg(4'd2, 1'b0, 4'd0, 1'b0);
    step(5);
    pulseDemand(1'b1, 1'b0);
    expectNow(1'b1, 1'b0, "R6 demand raises request");
    pulseAck(1'b1, 1'b0);
    expectNow(1'b0, 1'b0, "R6 ack after demand");
    step();
    expectNow(1'b0, 1'b0, "R6 stale expiry suppressed");
    step(5);
    expectNow(1'b0, 1'b0, "R6 restarted one tick early");
    step();
    expectNow(1'b1, 1'b0, "R6 restarted expiry");
    pulseAck(1'b1, 1'b0);

    // R7: changed timeout reloads, same value does not
    step(3);
    writeCfg(4'd3, 1'b0, 4'd0, 1'b0);
    step(3);
    expectNow(1'b0, 1'b0, "R7 stale period does not fire");
    step(8);
    expectNow(1'b0, 1'b0, "R7 reloaded one tick early");
    step();
    expectNow(1'b1, 1'b0, "R7 reloaded expiry");
    pulseAck(1'b1, 1'b0);
    writeCfg(4'd3, 1'b0, 4'd0, 1'b0);
    step(9);
    expectNow(1'b0, 1'b0, "R7 same-value write one tick early");
    step();
    expectNow(1'b1, 1'b0, "R7 same-value write keeps period");
    pulseAck(1'b1, 1'b0);
    writeCfg(4'd0, 1'b0, 4'd0, 1'b0);
    expectNow(1'b0, 1'b0, "R7 disabled again");

    // R9/R10/R11: merging and coincident trigger
    pulseDemand(1'b1, 1'b1);
    expectNow(1'b1, 1'b1, "R11 both demands");
    pulseDemand(1'b1, 1'b0);
    expectNow(1'b1, 1'b1, "R9 second demand merged");
    pulseAck(1'b1, 1'b1);
    expectNow(1'b0, 1'b0, "R9 single ack clears merged");
    pulseDemand(1'b1, 1'b0);
    expectNow(1'b1, 1'b0, "R10 tx request up");
    txDemand = 1'b1;
    txPollAck = 1'b1;
    step();
    txDemand = 1'b0;
    txPollAck = 1'b0;
    expectNow(1'b1, 1'b0, "R10 demand with ack keeps request");
    pulseAck(1'b1, 1'b0);
    expectNow(1'b0, 1'b0, "R10 later ack clears");

    // R11: separate periods, tx 4 ticks, rx 8 ticks
    writeCfg(4'd1, 1'b0, 4'd2, 1'b0);
    step(4);
    expectNow(1'b1, 1'b0, "R11 tx alone due");
    step(4);
    expectNow(1'b1, 1'b1, "R11 rx due later");
    pulseAck(1'b1, 1'b1);
    expectNow(1'b0, 1'b0, "R11 both acked");
    writeCfg(4'd0, 1'b0, 4'd0, 1'b0);
    expectNow(1'b0, 1'b0, "R11 quiet after disable");

    step(2);
    finishRun();
  end

endmodule